// File: doc/BRIEF.md
# Quarter-Wave Sine/Cosine Generator

This block turns a phase word, typically the upper bits of a numerically controlled oscillator's accumulator, into a pair of signed samples: the sine and the cosine of that phase. Both samples come out on the same clock cycle. Only one quarter period of the sine magnitude is kept in a table. The two most significant phase bits rebuild the other three quarters: one bit reflects the table address, the other negates the result. The cosine is taken from a second read port of the same table, addressed with the phase advanced by a quarter turn.

The latency is a parameter between 0 and 10 register stages. With zero stages the path is purely combinational, which suits tight loops such as an all-digital phase-locked loop. A valid flag travels through the same number of stages, so it always marks the cycle that carries a result. Each data register loads only when the valid flag at its input is set, so the outputs keep the last valid result while the input stream is idle.

Top module: `quarter_wave_sincos`

## Requirements
- R1: With phase width N, table depth D = 2^(N-2) and output width W, table entry k (0 <= k < D) holds M(k) = round(A*sin(pi*(k+0.5)/(2*D))), where A = 2^(W-1)-1. For the defaults N=10 and W=12, M(0)=6 and M(D-1)=2047.
- R2: In a rising quadrant (phase bits [N-1:N-2] = 00) the sine output equals +M(a), where a = phase[N-3:0].
- R3: When phase bit N-2 is 1 the table is read at the bit-inverted address, so quadrant 01 gives +M(D-1-a).
- R4: When phase bit N-1 is 1 the sine output is the two's complement negation of the value for the same phase with bit N-1 cleared, so quadrant 10 gives -M(a) and quadrant 11 gives -M(D-1-a).
- R5: The cosine output equals the sine of (phase + D) mod 2^N, that is, the top two phase bits plus 01.
- R6: The sine and the cosine of one input phase appear together, exactly STAGES clock cycles after that phase is presented with its valid flag. With STAGES = 0 they follow the input within the same cycle.
- R7: validOut equals validIn delayed by exactly STAGES cycles. While rstN is low and STAGES > 0, validOut is 0.
- R8: Neither output ever takes the value -2^(W-1). Both magnitudes stay at or below A.
- R9: With STAGES > 0, a cycle with validIn low loads no data register. Once the last valid result has reached the outputs, sinOut and cosOut keep it until a new valid phase arrives, whatever phaseIn does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the valid pipeline |
| phaseIn | input | PH_W | Phase word, full turn = 2^PH_W |
| validIn | input | 1 | Marks phaseIn as a sample to convert |
| sinOut | output | AMP_W | Signed sine sample |
| cosOut | output | AMP_W | Signed cosine sample |
| validOut | output | 1 | Marks sinOut and cosOut as valid |

## Verification
Every result is due exactly STAGES rising edges after its phase is presented. The bench therefore keeps a short ring of the phases and valid flags it drove. Shortly after each falling edge it compares the outputs against the entry pushed STAGES cycles earlier, so a result that arrives one cycle early or late shows up as a valid-flag or data mismatch. The hold check waits until the last valid result has passed all stages, then feeds idle cycles with a different phase and compares against that last result. The reset check reads validOut right after rstN falls, while valid samples are still in flight.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

  // Upper bound on the configurable register stages.
  localparam int MAX_STAGES = 10;

  // Load strobes from the control half to the datapath half:
  // bit i enables the register at pipeline position i.
  typedef struct packed {
    logic [MAX_STAGES-1:0] stageLoad;
  } stageCtrl_t;

endpackage

// File: rtl/sincos_ctrl.sv
module sincos_ctrl
  import sincos_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       validIn,
  output stageCtrl_t strobe,
  output logic       validOut
);

  // vldChain[i] is the valid flag in front of register position i.
  logic vldChain [STAGES+1];

  assign vldChain[0] = validIn;

  for (genvar i = 1; i <= STAGES; i++) begin : g_vld
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vldChain[i] <= 1'b0;
      end else begin
        vldChain[i] <= vldChain[i-1];
      end
    end
  end

  always_comb begin
    strobe = '0;
    for (int i = 0; i < STAGES; i++) begin
      strobe.stageLoad[i] = vldChain[i];
    end
  end

  assign validOut = vldChain[STAGES];

endmodule

// File: rtl/sincos_stage_reg.sv
module sincos_stage_reg
  import sincos_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 1,
  parameter int FIRST = 0
) (
  input  logic             clk,
  input  stageCtrl_t       strobe,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  if (DEPTH == 0) begin : g_pass
    assign dOut = dIn;
  end else begin : g_regs
    logic [WIDTH-1:0] regs [DEPTH];
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (strobe.stageLoad[FIRST]) begin
            regs[0] <= dIn;
          end
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (strobe.stageLoad[FIRST+i]) begin
            regs[i] <= regs[i-1];
          end
        end
      end
    end
    assign dOut = regs[DEPTH-1];
  end

endmodule

// File: rtl/sincos_quarter_rom.sv
module sincos_quarter_rom #(
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 12
) (
  input  logic [ADDR_W-1:0] addrSin,
  input  logic [ADDR_W-1:0] addrCos,
  output logic [AMP_W-2:0]  magSin,
  output logic [AMP_W-2:0]  magCos
);

  localparam int  DEPTH = 1 << ADDR_W;
  localparam int  MAG_W = AMP_W - 1;
  localparam int  PEAK  = (1 << (AMP_W - 1)) - 1;
  localparam real PI    = 3.14159265358979323846;

  // Half-sample offset makes entry k and entry DEPTH-1-k mirror images,
  // so plain bit inversion of the address reflects the quarter exactly.
  function automatic logic [MAG_W-1:0] calcMag(input int k);
    real ang;
    real scaled;
    int  v;
    ang    = PI * (real'(k) + 0.5) / (2.0 * real'(DEPTH));
    scaled = real'(PEAK) * $sin(ang) + 0.5;
    v      = $rtoi(scaled);
    return v[MAG_W-1:0];
  endfunction

  logic [MAG_W-1:0] quarterTab [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tab
    assign quarterTab[k] = calcMag(k);
  end

  // Two read ports on one table.
  assign magSin = quarterTab[addrSin];
  assign magCos = quarterTab[addrCos];

endmodule

// File: rtl/sincos_datapath.sv
module sincos_datapath
  import sincos_pkg::*;
#(
  parameter int PH_W   = 10,
  parameter int AMP_W  = 12,
  parameter int STAGES = 4
) (
  input  logic                    clk,
  input  stageCtrl_t              strobe,
  input  logic [PH_W-1:0]         phaseIn,
  output logic signed [AMP_W-1:0] sinOut,
  output logic signed [AMP_W-1:0] cosOut
);

  localparam int ADDR_W = PH_W - 2;
  localparam int MAG_W  = AMP_W - 1;
  localparam int FOLD_W = 2 + 2 * ADDR_W;
  localparam int ROM_W  = 2 + 2 * MAG_W;
  localparam int OUT_W  = 2 * AMP_W;
  localparam int N_FOLD = (STAGES >= 1) ? 1 : 0;
  localparam int N_ROM  = (STAGES >= 2) ? 1 : 0;
  localparam int N_TAIL = STAGES - N_FOLD - N_ROM;

  // ---------------- quadrant folding ----------------
  logic [1:0]        sinQuad, cosQuad;
  logic [ADDR_W-1:0] offset, sinAddr, cosAddr;
  logic [FOLD_W-1:0] foldBus, foldReg;

  always_comb begin
    sinQuad = phaseIn[PH_W-1 -: 2];
    cosQuad = sinQuad + 2'b01;
    offset  = phaseIn[ADDR_W-1:0];
    sinAddr = sinQuad[0] ? ~offset : offset;
    cosAddr = cosQuad[0] ? ~offset : offset;
    foldBus = {sinQuad[1], cosQuad[1], sinAddr, cosAddr};
  end

  sincos_stage_reg #(.WIDTH(FOLD_W), .DEPTH(N_FOLD), .FIRST(0)) u_foldStage (
    .clk   (clk),
    .strobe(strobe),
    .dIn   (foldBus),
    .dOut  (foldReg)
  );

  // ---------------- table read ----------------
  logic              sinNegA, cosNegA;
  logic [ADDR_W-1:0] sinAddrR, cosAddrR;
  logic [MAG_W-1:0]  magSin, magCos;
  logic [ROM_W-1:0]  romBus, romReg;

  assign {sinNegA, cosNegA, sinAddrR, cosAddrR} = foldReg;

  sincos_quarter_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
    .addrSin(sinAddrR),
    .addrCos(cosAddrR),
    .magSin (magSin),
    .magCos (magCos)
  );

  assign romBus = {sinNegA, cosNegA, magSin, magCos};

  sincos_stage_reg #(.WIDTH(ROM_W), .DEPTH(N_ROM), .FIRST(N_FOLD)) u_romStage (
    .clk   (clk),
    .strobe(strobe),
    .dIn   (romBus),
    .dOut  (romReg)
  );

  // ---------------- sign restore ----------------
  logic                    sinNegB, cosNegB;
  logic [MAG_W-1:0]        magSinR, magCosR;
  logic signed [AMP_W-1:0] sinVal, cosVal;
  logic [OUT_W-1:0]        outBus, outReg;

  assign {sinNegB, cosNegB, magSinR, magCosR} = romReg;

  always_comb begin
    sinVal = sinNegB ? -$signed({1'b0, magSinR}) : $signed({1'b0, magSinR});
    cosVal = cosNegB ? -$signed({1'b0, magCosR}) : $signed({1'b0, magCosR});
    outBus = {sinVal, cosVal};
  end

  sincos_stage_reg #(.WIDTH(OUT_W), .DEPTH(N_TAIL), .FIRST(N_FOLD + N_ROM)) u_tailStage (
    .clk   (clk),
    .strobe(strobe),
    .dIn   (outBus),
    .dOut  (outReg)
  );

  assign sinOut = $signed(outReg[OUT_W-1:AMP_W]);
  assign cosOut = $signed(outReg[AMP_W-1:0]);

endmodule

// File: rtl/quarter_wave_sincos.sv
module quarter_wave_sincos
  import sincos_pkg::*;
#(
  parameter int PH_W   = 10,
  parameter int AMP_W  = 12,
  parameter int STAGES = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [PH_W-1:0]         phaseIn,
  input  logic                    validIn,
  output logic signed [AMP_W-1:0] sinOut,
  output logic signed [AMP_W-1:0] cosOut,
  output logic                    validOut
);

  if (STAGES < 0 || STAGES > MAX_STAGES) begin : g_badStages
    $error("STAGES must lie between 0 and MAX_STAGES");
  end
  if (PH_W < 3 || AMP_W < 3) begin : g_badWidth
    $error("PH_W and AMP_W must each be at least 3");
  end

  stageCtrl_t strobe;

  sincos_ctrl #(.STAGES(STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .validIn (validIn),
    .strobe  (strobe),
    .validOut(validOut)
  );

  sincos_datapath #(.PH_W(PH_W), .AMP_W(AMP_W), .STAGES(STAGES)) u_dp (
    .clk    (clk),
    .strobe (strobe),
    .phaseIn(phaseIn),
    .sinOut (sinOut),
    .cosOut (cosOut)
  );

endmodule

// File: rtl/sincos_checker.sv
module sincos_checker #(
  parameter int PH_W   = 10,
  parameter int AMP_W  = 12,
  parameter int STAGES = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [PH_W-1:0]         phaseIn,
  input logic                    validIn,
  input logic signed [AMP_W-1:0] sinOut,
  input logic signed [AMP_W-1:0] cosOut,
  input logic                    validOut
);

  localparam logic signed [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

  // Cycles since reset, saturating at STAGES: history is trusted only when full.
  logic [3:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upCnt <= '0;
    end else if (upCnt < 4'(STAGES)) begin
      upCnt <= upCnt + 4'd1;
    end
  end
  wire histFull = (upCnt == 4'(STAGES));

  logic            vHist [STAGES+1];
  logic [PH_W-1:0] pHist [STAGES+1];
  assign vHist[0] = validIn;
  assign pHist[0] = phaseIn;
  for (genvar i = 1; i <= STAGES; i++) begin : g_hist
    always_ff @(posedge clk) begin
      vHist[i] <= vHist[i-1];
      pHist[i] <= pHist[i-1];
    end
  end
  wire            vDue = vHist[STAGES];
  wire [PH_W-1:0] pDue = pHist[STAGES];

  p_valid_delay_r7: assert property (@(posedge clk) disable iff (!rstN)
    histFull |-> (validOut == vDue));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> (sinOut != MOST_NEG && cosOut != MOST_NEG));

  p_sine_sign_r4: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && histFull) |-> (sinOut[AMP_W-1] == pDue[PH_W-1]));

  p_cos_sign_r5: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && histFull) |-> (cosOut[AMP_W-1] == (pDue[PH_W-1] ^ pDue[PH_W-2])));

  if (STAGES > 0) begin : g_hold
    logic sawData;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sawData <= 1'b0;
      end else if (validOut) begin
        sawData <= 1'b1;
      end
    end
    p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      (sawData && !validOut) |-> ($stable(sinOut) && $stable(cosOut)));
  end

endmodule

bind quarter_wave_sincos sincos_checker #(.PH_W(PH_W), .AMP_W(AMP_W), .STAGES(STAGES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .phaseIn (phaseIn),
  .validIn (validIn),
  .sinOut  (sinOut),
  .cosOut  (cosOut),
  .validOut(validOut)
);

// File: tb/sim_quarter_wave_sincos.sv
module sim_quarter_wave_sincos;

  localparam int  PH_W   = 10;
  localparam int  AMP_W  = 12;
  localparam int  STAGES = 4;
  localparam int  D      = 1 << (PH_W - 2);
  localparam int  TURN   = 1 << PH_W;
  localparam int  PEAK   = (1 << (AMP_W - 1)) - 1;
  localparam real PI     = 3.14159265358979323846;

  // {valid, phase}: quadrant edges, mid-quadrant points and gaps.
  localparam int NV = 16;
  localparam logic [PH_W:0] VEC [NV] = '{
    {1'b1, 10'd0},   {1'b1, 10'd255}, {1'b1, 10'd256}, {1'b1, 10'd511},
    {1'b1, 10'd512}, {1'b0, 10'd100}, {1'b1, 10'd767}, {1'b1, 10'd768},
    {1'b1, 10'd1023},{1'b1, 10'd128}, {1'b0, 10'd900}, {1'b0, 10'd3},
    {1'b1, 10'd384}, {1'b1, 10'd640}, {1'b1, 10'd896}, {1'b1, 10'd1}
  };

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic [PH_W-1:0]         phaseIn = '0;
  logic                    validIn = 1'b0;
  logic signed [AMP_W-1:0] sinOut, cosOut;
  logic                    validOut;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic            histV [16];
  logic [PH_W-1:0] histP [16];

  always #2.5 clk = ~clk;

  quarter_wave_sincos #(.PH_W(PH_W), .AMP_W(AMP_W), .STAGES(STAGES)) u0 (
    .clk(clk), .rstN(rstN), .phaseIn(phaseIn), .validIn(validIn),
    .sinOut(sinOut), .cosOut(cosOut), .validOut(validOut)
  );

  // R1 table magnitude as the requirement defines it.
  function automatic int mag(input int k);
    return $rtoi(real'(PEAK) * $sin(PI * (real'(k) + 0.5) / (2.0 * real'(D))) + 0.5);
  endfunction

  function automatic int expSin(input int p);
    int q, a, m;
    q = (p / D) % 4;
    a = p % D;
    m = (q % 2 == 1) ? mag(D - 1 - a) : mag(a);   // R2 / R3
    return (q >= 2) ? -m : m;                      // R4
  endfunction

  function automatic int expCos(input int p);
    return expSin((p + D) % TURN);                 // R5
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Drive one cycle; compare outputs with the entry driven STAGES cycles earlier (R6).
  task automatic tick(input logic v, input int p);
    int idx;
    @(negedge clk);
    validIn = v;
    phaseIn = PH_W'(p);
    histV[cyc % 16] = v;
    histP[cyc % 16] = PH_W'(p);
    #1;
    if (cyc >= STAGES) begin
      idx = (cyc - STAGES) % 16;
      check(validOut == histV[idx], "R7 R6 validOut", int'(validOut), int'(histV[idx]));
      if (histV[idx]) begin
        check(int'(sinOut) == expSin(int'(histP[idx])), "R2 R3 R4 R6 sine",
              int'(sinOut), expSin(int'(histP[idx])));
        check(int'(cosOut) == expCos(int'(histP[idx])), "R5 R6 cosine",
              int'(cosOut), expCos(int'(histP[idx])));
        check(sinOut != -(PEAK + 1) && cosOut != -(PEAK + 1), "R8 range",
              int'(sinOut), -PEAK);
      end
    end
    cyc++;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    validIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    // Reset state
    repeat (3) @(negedge clk);
    #1;
    check(validOut == 1'b0, "R7 reset", int'(validOut), 0);
    rstN = 1'b1;
    cyc = 0;

    // R1: explicit table entries at the quadrant edges
    for (int i = 0; i < 2; i++) tick(1'b1, (i == 0) ? 0 : D - 1);
    for (int i = 0; i < STAGES; i++) tick(1'b0, 0);
    @(negedge clk);
    validIn = 1'b1; phaseIn = '0;
    for (int i = 0; i < STAGES; i++) @(negedge clk);
    #1;
    check(int'(sinOut) == 6, "R1 M(0)", int'(sinOut), 6);
    check(int'(cosOut) == PEAK, "R1 M(D-1) via cosine", int'(cosOut), PEAK);
    validIn = 1'b0;
    doReset();

    // Vector table with gaps in valid
    for (int i = 0; i < NV; i++) tick(VEC[i][PH_W], int'(VEC[i][PH_W-1:0]));
    for (int i = 0; i < STAGES; i++) tick(1'b0, 5);

    // Full sweep of every phase
    for (int p = 0; p < TURN; p++) tick(1'b1, p);
    for (int i = 0; i < STAGES; i++) tick(1'b0, 77);

    // R9: idle cycles with a different phase leave the last result in place
    for (int i = 0; i < 3; i++) tick(1'b0, 300 + i);
    if (STAGES > 0) begin
      check(int'(sinOut) == expSin(TURN - 1), "R9 hold sine", int'(sinOut), expSin(TURN - 1));
      check(int'(cosOut) == expCos(TURN - 1), "R9 hold cosine", int'(cosOut), expCos(TURN - 1));
    end

    // R7: reset while valid samples are in flight
    for (int i = 0; i < 2; i++) tick(1'b1, 40 + i);
    @(negedge clk);
    rstN = 1'b0;
    validIn = 1'b0;
    #1;
    if (STAGES > 0) check(validOut == 1'b0, "R7 reset in flight", int'(validOut), 0);
    repeat (STAGES + 1) @(negedge clk);
    #1;
    check(validOut == 1'b0, "R7 held in reset", int'(validOut), 0);
    rstN = 1'b1;
    cyc = 0;
    for (int i = 0; i < STAGES + 2; i++) tick(1'b0, 9);

    report();
  end

endmodule